// File: doc/BRIEF.md
# Reconfigurable Timer/Counter with Capture

This block is a 16-bit counting datapath that a 2-bit mode input splits into two 8-bit halves or joins into one 16-bit counter. Each half, or the joined pair, advances from one of two sources. The first is an 8-bit programmable divider of the system tick. The second is the rising edges of an external event pin. Each half reloads to zero when it passes its match value and pulses a flag for one cycle when it does.

The halves have two capture strobes. A capture copies the live count into a holding register, at 8-bit width or 16-bit width to suit the mode. Match values and the divider setting are loaded through a small write port. The counts, the captured values and the flags are outputs, ready for an interrupt controller or for software polling logic placed around the block.

There are four modes. In SPLIT (0) both halves are divided-tick timers. In MIX (1) the low half is a divided-tick timer and the high half counts events. In WIDE (2) the pair is one 16-bit divided-tick timer. In WEVT (3) the pair is one 16-bit event counter.

Top module: `mtc_top`

## Requirements
- R1: After reset, both counts, both capture registers and both flags are 0, the divider setting is 0 and both match registers are 0xFF.
- R2: The divider produces one advance for every (D+1) cycles with `tick` high, where D is the divider setting. A write to the divider clears its phase.
- R3: In SPLIT and MIX the low half counts 0..ML, where ML is the low match value. The advance taken at ML reloads the half to 0 and raises `flag_lo` for exactly that one cycle, the same cycle in which the count reads 0.
- R4: In SPLIT the high half is a divided-tick timer with its own match value MH. It is independent of the low half and pulses `flag_hi` when it reloads.
- R5: In MIX the high half counts the rising edges of `evt_in`. A pulse that is high for one cycle and low for one cycle is counted once.
- R6: In WIDE the pair {hi,lo} is one 16-bit divided-tick timer whose match is {MH,ML}. Only `flag_hi` pulses on the 16-bit reload, and `flag_lo` stays 0.
- R7: In WEVT the pair {hi,lo} counts `evt_in` rising edges against the 16-bit match {MH,ML} and reloads to 0.
- R8: In the split modes, a rising edge on `cap_lo_in` copies the low count into `cap_lo`, and a rising edge on `cap_hi_in` copies the high count into `cap_hi`.
- R9: In the 16-bit modes, a rising edge on `cap_lo_in` copies the full count into {`cap_hi`,`cap_lo`}. `cap_hi_in` has no effect.
- R10: When a capture and an advance fall in the same cycle, the captured value is the count before that advance.
- R11: A write with `wr_addr` 0 loads ML, 1 loads MH and 2 loads D. Address 3 changes nothing.
- R12: In the divided-tick modes the counts do not move while `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | System tick enable that feeds the divider |
| mode | input | 2 | 0 SPLIT, 1 MIX, 2 WIDE, 3 WEVT |
| evt_in | input | 1 | External event pin (asynchronous) |
| cap_lo_in | input | 1 | Low capture strobe (asynchronous) |
| cap_hi_in | input | 1 | High capture strobe (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 ML, 1 MH, 2 divider, 3 unused |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 8 | Low count |
| cnt_hi | output | 8 | High count |
| cap_lo | output | 8 | Low capture register |
| cap_hi | output | 8 | High capture register |
| flag_lo | output | 1 | One-cycle low reload pulse |
| flag_hi | output | 1 | One-cycle high (or 16-bit) reload pulse |

## Verification
The bench sweeps divider settings against match values, including a match of 3 and a match above 128. An off-by-one in the divider or in the reload point would show up as a count that is one step off and as a wrong number of flag pulses. The 16-bit modes are run past a match whose low byte is smaller than the count's low byte. A design that reloaded each half on its own would wrap early there, or would pulse `flag_lo`. The bench drives an event edge and a capture edge in the same cycle. A design that captured after the advance would hold one more than the expected value. One-cycle event pulses catch an edge detector that merges back-to-back events, and a write to the unused address catches a decoder that folds it onto the divider or a match register.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    typedef enum logic [1:0] {
        M_SPLIT = 2'd0,
        M_MIX   = 2'd1,
        M_WIDE  = 2'd2,
        M_WEVT  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        A_MATCH_LO = 2'd0,
        A_MATCH_HI = 2'd1,
        A_DIVIDER  = 2'd2,
        A_UNUSED   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/mtc_edge_sync.sv
module mtc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/mtc_prescale.sv
module mtc_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [PW-1:0] div,
    output logic          en
);
    logic [PW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (clr)
            phase <= '0;
        else if (tick)
            phase <= (phase == div) ? '0 : phase + 1'b1;
    end

    assign en = tick && !clr && (phase == div);
endmodule

// File: rtl/mtc_top.sv
module mtc_top
    import mtc_pkg::*;
#(
    parameter int HW  = 8,
    parameter int PW  = 8,
    parameter int WDW = (HW > PW) ? HW : PW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [1:0]     mode,
    input  logic           evt_in,
    input  logic           cap_lo_in,
    input  logic           cap_hi_in,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [WDW-1:0] wr_data,
    output logic [HW-1:0]  cnt_lo,
    output logic [HW-1:0]  cnt_hi,
    output logic [HW-1:0]  cap_lo,
    output logic [HW-1:0]  cap_hi,
    output logic           flag_lo,
    output logic           flag_hi
);
    localparam int DW     = 2 * HW;
    localparam int NSYNC  = 3;
    localparam int S_EVT  = 0;
    localparam int S_CLO  = 1;
    localparam int S_CHI  = 2;

    tmr_mode_e     mode_e;
    logic [NSYNC-1:0] pin_vec, rise_vec;
    logic          pre_en, pre_clr;
    logic [HW-1:0] match_lo, match_hi;
    logic [PW-1:0] div_q;
    logic          lo_inc, hi_inc, wide;
    logic [DW-1:0] full_cnt, full_match;
    logic [HW-1:0] lo_n, hi_n, clo_n, chi_n;
    logic          fl_n, fh_n;

    assign mode_e  = tmr_mode_e'(mode);
    assign pin_vec = {cap_hi_in, cap_lo_in, evt_in};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        mtc_edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_vec[g]),
            .rise (rise_vec[g])
        );
    end

    assign pre_clr = wr_en && (wr_addr == A_DIVIDER);

    mtc_prescale #(.PW(PW)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (pre_clr),
        .div  (div_q),
        .en   (pre_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_lo <= '1;
            match_hi <= '1;
            div_q    <= '0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_MATCH_LO: match_lo <= wr_data[HW-1:0];
                A_MATCH_HI: match_hi <= wr_data[HW-1:0];
                A_DIVIDER:  div_q    <= wr_data[PW-1:0];
                A_UNUSED:   ;
            endcase
        end
    end

    always_comb begin
        lo_inc = 1'b0;
        hi_inc = 1'b0;
        wide   = 1'b0;
        unique case (mode_e)
            M_SPLIT: begin lo_inc = pre_en;          hi_inc = pre_en;          end
            M_MIX:   begin lo_inc = pre_en;          hi_inc = rise_vec[S_EVT]; end
            M_WIDE:  begin lo_inc = pre_en;          wide   = 1'b1;            end
            M_WEVT:  begin lo_inc = rise_vec[S_EVT]; wide   = 1'b1;            end
        endcase
    end

    assign full_cnt   = {cnt_hi, cnt_lo};
    assign full_match = {match_hi, match_lo};

    always_comb begin
        lo_n  = cnt_lo;
        hi_n  = cnt_hi;
        fl_n  = 1'b0;
        fh_n  = 1'b0;
        clo_n = cap_lo;
        chi_n = cap_hi;
        if (wide) begin
            if (lo_inc) begin
                if (full_cnt == full_match) begin
                    {hi_n, lo_n} = '0;
                    fh_n = 1'b1;
                end else begin
                    {hi_n, lo_n} = full_cnt + 1'b1;
                end
            end
            if (rise_vec[S_CLO])
                {chi_n, clo_n} = full_cnt;
        end else begin
            if (lo_inc) begin
                fl_n = (cnt_lo == match_lo);
                lo_n = fl_n ? '0 : cnt_lo + 1'b1;
            end
            if (hi_inc) begin
                fh_n = (cnt_hi == match_hi);
                hi_n = fh_n ? '0 : cnt_hi + 1'b1;
            end
            if (rise_vec[S_CLO]) clo_n = cnt_lo;
            if (rise_vec[S_CHI]) chi_n = cnt_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo  <= '0;
            cnt_hi  <= '0;
            cap_lo  <= '0;
            cap_hi  <= '0;
            flag_lo <= 1'b0;
            flag_hi <= 1'b0;
        end else begin
            cnt_lo  <= lo_n;
            cnt_hi  <= hi_n;
            cap_lo  <= clo_n;
            cap_hi  <= chi_n;
            flag_lo <= fl_n;
            flag_hi <= fh_n;
        end
    end
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
    parameter int HW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    mode,
    input logic [HW-1:0] cnt_lo,
    input logic [HW-1:0] cnt_hi,
    input logic          flag_lo,
    input logic          flag_hi
);
    logic [HW-1:0] one_v;
    assign one_v = {{(HW-1){1'b0}}, 1'b1};

    a_r3_flag_lo_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_lo |-> (cnt_lo == '0));

    a_r4_flag_hi_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hi |-> (cnt_hi == '0));

    a_r6_no_lo_flag_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && $past(mode[1])) |-> !flag_lo);

    a_r3_lo_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo != $past(cnt_lo)) |-> ((cnt_lo == $past(cnt_lo) + one_v) || (cnt_lo == '0)));

    a_r7_hi_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hi != $past(cnt_hi)) |-> ((cnt_hi == $past(cnt_hi) + one_v) || (cnt_hi == '0)));

    a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !mode[0]) |=> $stable({cnt_hi, cnt_lo}));
endmodule

bind mtc_top mtc_checker #(.HW(HW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .mode   (mode),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .flag_lo(flag_lo),
    .flag_hi(flag_hi)
);

// File: tb/tb_mtc_top.sv
module tb_mtc_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [1:0] mode;
    logic       evt_in, cap_lo_in, cap_hi_in;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
    logic       flag_lo, flag_hi;

    int errors = 0;
    int checks = 0;
    int nfl = 0;
    int nfh = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mtc_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .evt_in(evt_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .flag_lo(flag_lo), .flag_hi(flag_hi)
    );

    always @(negedge clk) begin
        if (rst_n && flag_lo) nfl++;
        if (rst_n && flag_hi) nfh++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; mode = m; evt_in = 1'b0;
        cap_lo_in = 1'b0; cap_hi_in = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nfl = 0; nfh = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic events(input int n, input int hi_c, input int lo_c);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1;
            repeat (hi_c) @(negedge clk);
            evt_in = 1'b0;
            repeat (lo_c) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic strobe_lo();
        cap_lo_in = 1'b1; repeat (2) @(negedge clk);
        cap_lo_in = 1'b0; repeat (5) @(negedge clk);
    endtask

    task automatic strobe_hi();
        cap_hi_in = 1'b1; repeat (2) @(negedge clk);
        cap_hi_in = 1'b0; repeat (5) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int divs[4];
        int mts[3];
        divs = '{0, 1, 2, 5};
        mts  = '{3, 7, 200};

        // R1 reset state
        do_reset(2'd0);
        chk("R1 cnt_lo", cnt_lo, 0);
        chk("R1 cnt_hi", cnt_hi, 0);
        chk("R1 cap_lo", cap_lo, 0);
        chk("R1 cap_hi", cap_hi, 0);
        chk("R1 flags", {flag_hi, flag_lo}, 0);
        ticks(300);
        chk("R1 default match 0xFF lo", cnt_lo, 300 % 256);
        chk("R1 default match 0xFF flag_lo", nfl, 1);

        // R11 unused address changes nothing
        do_reset(2'd0);
        wr(2'd3, 8'd2);
        ticks(10);
        chk("R11 addr3 ignored", cnt_lo, 10);

        // R2 R3 R4 sweep in SPLIT
        foreach (divs[i]) begin
            foreach (mts[j]) begin
                int incs, mh;
                do_reset(2'd0);
                mh = mts[j] / 2 + 1;
                wr(2'd0, 8'(mts[j]));
                wr(2'd1, 8'(mh));
                wr(2'd2, 8'(divs[i]));
                ticks(60);
                incs = 60 / (divs[i] + 1);
                chk("R2 R3 lo count", cnt_lo, incs % (mts[j] + 1));
                chk("R3 flag_lo pulses", nfl, incs / (mts[j] + 1));
                chk("R4 hi count", cnt_hi, incs % (mh + 1));
                chk("R4 flag_hi pulses", nfh, incs / (mh + 1));
            end
        end

        // R12 and R8 capture in SPLIT
        do_reset(2'd0);
        wr(2'd2, 8'd1);
        ticks(14);
        repeat (20) @(negedge clk);
        chk("R12 no advance without tick", cnt_lo, 7);
        strobe_lo();
        chk("R8 cap_lo", cap_lo, 7);
        chk("R8 cap_hi untouched by lo strobe", cap_hi, 0);
        ticks(4);
        strobe_hi();
        chk("R8 cap_hi", cap_hi, 9);
        chk("R8 cap_lo untouched by hi strobe", cap_lo, 7);

        // R5 MIX
        do_reset(2'd1);
        wr(2'd0, 8'd9);
        wr(2'd1, 8'd4);
        wr(2'd2, 8'd3);
        ticks(100);
        chk("R5 mix lo timer", cnt_lo, 5);
        chk("R5 mix hi ignores tick", cnt_hi, 0);
        events(13, 1, 1);
        chk("R5 one-cycle events", cnt_hi, 13 % 5);
        chk("R5 flag_hi pulses", nfh, 2);
        chk("R12 lo still", cnt_lo, 5);

        // R6 WIDE
        do_reset(2'd2);
        wr(2'd0, 8'h23);
        wr(2'd1, 8'h01);
        ticks(700);
        chk("R6 wide count", {cnt_hi, cnt_lo}, 700 % 292);
        chk("R6 flag_hi pulses", nfh, 2);
        chk("R6 flag_lo silent", nfl, 0);
        strobe_lo();
        chk("R9 16-bit capture", {cap_hi, cap_lo}, 116);
        ticks(5);
        strobe_hi();
        chk("R9 hi strobe ignored", {cap_hi, cap_lo}, 116);

        // R7 WEVT and R10
        do_reset(2'd3);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h01);
        events(300, 2, 2);
        chk("R7 event count", {cnt_hi, cnt_lo}, 300 % 262);
        chk("R7 flag_hi pulses", nfh, 1);
        evt_in = 1'b1; cap_lo_in = 1'b1;
        repeat (2) @(negedge clk);
        evt_in = 1'b0; cap_lo_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 pre-advance capture", {cap_hi, cap_lo}, 38);
        chk("R10 count advanced", {cnt_hi, cnt_lo}, 39);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule